// File: doc/BRIEF.md
# Random Number Source Register Front-End

This block is the software-facing register layer of a hardware random number generator. An entropy source, outside the block, offers 32-bit words with a valid flag. The block holds those words in a small first-in first-out buffer. Software reaches everything through a simple 32-bit register bus. It can switch generation on and off, hold either of two generator stages in soft reset, read the health-failure flags and clear them, read how many words are waiting, and pull words out one at a time.

Bus reads are combinational. Read data reflects the address presented in the same cycle. Any side effect of an access, such as a pop or a register update, takes place at the following rising clock edge. Two failure-injection inputs stand in for the health monitors of the real source. While a soft reset is held, the buffer is emptied and refuses new words. Software typically reacts to a health flag by raising and then releasing the resets, clearing the flags and re-enabling generation.

Top module: `rng_regfront`

## Requirements
- R1: The control register at offset 0x00 stores a 13-bit field in bits 12:0. Bits 31:13 read as zero, and the field resets to zero. Bit 0 of the field is the generation enable.
- R2: Two soft-reset registers, at offset 0x04 (conditioned stage) and offset 0x08 (raw stage), each store bit 0. Their other bits read zero, and both reset to zero.
- R3: While either soft-reset bit is 1, the word count reads zero and the data port reads zero. The buffer is emptied at every clock edge, `srcReady` is low, and no source word is taken. Releasing the reset leaves the buffer empty.
- R4: A source word is taken at a clock edge only when `srcReady` is high. `srcReady` is high exactly when the enable bit is 1, no soft reset is held and fewer than 16 words are stored. The count never exceeds 16.
- R5: A read of offset 0x20 returns the oldest stored word and removes it at the next edge. Words leave in the order they arrived.
- R6: A read of offset 0x20 while the buffer is empty returns zero and leaves the count at zero.
- R7: A read of offset 0x24 returns the number of stored words in bits 7:0, with bits 31:8 zero.
- R8: The status register at offset 0x18 holds a lockout flag in bit 31 and a statistical-test failure flag in bit 5. A high `injLockout` or `injHealthFail` at an edge sets the matching flag, and the flag stays set. All other status bits read zero.
- R9: Writing to offset 0x18 clears each flag whose bit in the write data is 1 and leaves flags written with 0 unchanged, so all-ones clears both. An injection in the same cycle as a clear leaves the flag set.
- R10: A pop and an accepted source word in the same cycle leave the count unchanged.
- R11: Reads of unmapped offsets return zero. Writes to offsets 0x20, 0x24 or unmapped offsets change no register and no stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| busSel | input | 1 | Register access in this cycle |
| busWrite | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | 8 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from address |
| srcValid | input | 1 | Source offers a word |
| srcData | input | 32 | Source word |
| srcReady | output | 1 | Block takes the offered word at the edge |
| injLockout | input | 1 | Sets the lockout flag |
| injHealthFail | input | 1 | Sets the statistical-test failure flag |

## Verification
The bench builds the block with its default parameters: a 16-word buffer, 32-bit words and an 8-bit count field. A depth of 16 lets a handful of directed pushes reach the full boundary, where `srcReady` drops and further words are refused. The random phase then returns to that boundary again and again, mixed with pops, empty reads, soft resets and flag injections. These parameter values keep same-cycle push-with-pop and clear-against-injection collisions frequent enough to be hit many times.

// File: rtl/rng_regfront_pkg.sv
package rng_regfront_pkg;

  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_CTRL     = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_RST_COND = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_RST_RAW  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_STATUS   = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_DATA     = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_COUNT    = 8'h24;

  localparam int LOCK_BIT   = 31;
  localparam int HEALTH_BIT = 5;

  // Strobes from the register control to the datapath
  typedef struct packed {
    logic genEnable;
    logic flush;
    logic pop;
    logic clrLock;
    logic clrHealth;
  } strobe_t;

endpackage

// File: rtl/rng_regfront_ctrl.sv
module rng_regfront_ctrl
  import rng_regfront_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CTRL_W = 13,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output strobe_t           strobes,
  input  logic [CNT_W-1:0]  dpCount,
  input  logic [DATA_W-1:0] dpHead,
  input  logic              dpLock,
  input  logic              dpHealth
);

  localparam int NUM_SRST = 2;
  localparam logic [ADDR_W-1:0] SRST_OFS [NUM_SRST] = '{OFS_RST_COND, OFS_RST_RAW};

  logic              wrHit;
  logic              rdHit;
  logic [CTRL_W-1:0] ctrlField;
  logic [NUM_SRST-1:0] softRst;

  assign wrHit = busSel && busWrite;
  assign rdHit = busSel && !busWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlField <= '0;
    end else if (wrHit && busAddr == OFS_CTRL) begin
      ctrlField <= busWdata[CTRL_W-1:0];
    end
  end

  // One single-bit soft reset register per generator stage
  for (genvar i = 0; i < NUM_SRST; i++) begin : g_srst
    logic bitQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bitQ <= 1'b0;
      end else if (wrHit && busAddr == SRST_OFS[i]) begin
        bitQ <= busWdata[0];
      end
    end
    assign softRst[i] = bitQ;
  end

  always_comb begin
    strobes.genEnable = ctrlField[0];
    strobes.flush     = |softRst;
    strobes.pop       = rdHit && busAddr == OFS_DATA;
    strobes.clrLock   = wrHit && busAddr == OFS_STATUS && busWdata[LOCK_BIT];
    strobes.clrHealth = wrHit && busAddr == OFS_STATUS && busWdata[HEALTH_BIT];
  end

  always_comb begin
    busRdata = '0;
    if (rdHit) begin
      case (busAddr)
        OFS_CTRL:     busRdata[CTRL_W-1:0] = ctrlField;
        OFS_RST_COND: busRdata[0] = softRst[0];
        OFS_RST_RAW:  busRdata[0] = softRst[1];
        OFS_STATUS: begin
          busRdata[LOCK_BIT]   = dpLock;
          busRdata[HEALTH_BIT] = dpHealth;
        end
        OFS_DATA:     busRdata = dpHead;
        OFS_COUNT:    busRdata[CNT_W-1:0] = dpCount;
        default:      busRdata = '0;
      endcase
    end
  end

  // R2: a write to a soft reset register lands in bit 0 one edge later
  a_r2_cond_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrHit && busAddr == OFS_RST_COND) |=> (softRst[0] == $past(busWdata[0])));
  a_r2_raw_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrHit && busAddr == OFS_RST_RAW) |=> (softRst[1] == $past(busWdata[0])));
  // R11: a write elsewhere leaves the control field as it was
  a_r11_ctrl_kept: assert property (@(posedge clk) disable iff (!rstN)
    (wrHit && busAddr != OFS_CTRL) |=> $stable(ctrlField));

endmodule

// File: rtl/rng_regfront_datapath.sv
module rng_regfront_datapath
  import rng_regfront_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic              srcValid,
  input  logic [DATA_W-1:0] srcData,
  output logic              srcReady,
  input  logic              injLockout,
  input  logic              injHealthFail,
  output logic [CNT_W-1:0]  dpCount,
  output logic [DATA_W-1:0] dpHead,
  output logic              dpLock,
  output logic              dpHealth
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [OCC_W-1:0] FULL_OCC = OCC_W'(DEPTH);
  localparam int NUM_FLAGS = 2;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  logic [OCC_W-1:0]  occ;
  logic              empty;
  logic              full;
  logic              push;
  logic              popEff;

  assign empty    = (occ == '0);
  assign full     = (occ == FULL_OCC);
  assign srcReady = strobes.genEnable && !full && !strobes.flush;
  assign push     = srcValid && srcReady;
  assign popEff   = strobes.pop && !empty && !strobes.flush;

  always_ff @(posedge clk) begin
    if (push) begin
      mem[wrPtr] <= srcData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      occ   <= '0;
    end else if (strobes.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      occ   <= '0;
    end else begin
      if (push) begin
        wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      end
      if (popEff) begin
        rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      end
      case ({push, popEff})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  assign dpHead  = (empty || strobes.flush) ? '0 : mem[rdPtr];
  assign dpCount = strobes.flush ? '0 : CNT_W'(occ);

  // Sticky health flags: index 0 lockout, index 1 statistical-test failure
  logic [NUM_FLAGS-1:0] flagSet;
  logic [NUM_FLAGS-1:0] flagClr;
  logic [NUM_FLAGS-1:0] flagQ;

  assign flagSet = {injHealthFail, injLockout};
  assign flagClr = {strobes.clrHealth, strobes.clrLock};

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        flagQ[i] <= 1'b0;
      end else begin
        flagQ[i] <= (flagQ[i] && !flagClr[i]) || flagSet[i];
      end
    end
  end

  assign dpLock   = flagQ[0];
  assign dpHealth = flagQ[1];

  // R4: occupancy is bounded by the depth
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    occ <= FULL_OCC);
  // R4: a full buffer refuses the source
  a_r4_full_refuses: assert property (@(posedge clk) disable iff (!rstN)
    full |-> !srcReady);
  // R3: a held soft reset leaves the buffer empty
  a_r3_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    strobes.flush |=> (occ == '0));
  // R6: popping an empty buffer keeps the count at zero
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    (empty && !push) |=> (occ == '0));
  // R10: push with pop holds the count
  a_r10_push_pop_hold: assert property (@(posedge clk) disable iff (!rstN)
    (push && popEff) |=> (occ == $past(occ)));
  // R8: injection sets the flag at the next edge
  a_r8_lock_set: assert property (@(posedge clk) disable iff (!rstN)
    injLockout |=> dpLock);
  a_r8_health_set: assert property (@(posedge clk) disable iff (!rstN)
    injHealthFail |=> dpHealth);
  // R9: a clear without injection drops the flag
  a_r9_lock_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clrLock && !injLockout) |=> !dpLock);
  a_r9_health_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clrHealth && !injHealthFail) |=> !dpHealth);

endmodule

// File: rtl/rng_regfront.sv
module rng_regfront
  import rng_regfront_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int CTRL_W = 13,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              srcValid,
  input  logic [DATA_W-1:0] srcData,
  output logic              srcReady,
  input  logic              injLockout,
  input  logic              injHealthFail
);

  strobe_t           strobes;
  logic [CNT_W-1:0]  dpCount;
  logic [DATA_W-1:0] dpHead;
  logic              dpLock;
  logic              dpHealth;

  rng_regfront_ctrl #(
    .DATA_W(DATA_W),
    .CTRL_W(CTRL_W),
    .CNT_W (CNT_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busSel  (busSel),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .strobes (strobes),
    .dpCount (dpCount),
    .dpHead  (dpHead),
    .dpLock  (dpLock),
    .dpHealth(dpHealth)
  );

  rng_regfront_datapath #(
    .DATA_W(DATA_W),
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
  ) u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .srcValid     (srcValid),
    .srcData      (srcData),
    .srcReady     (srcReady),
    .injLockout   (injLockout),
    .injHealthFail(injHealthFail),
    .dpCount      (dpCount),
    .dpHead       (dpHead),
    .dpLock       (dpLock),
    .dpHealth     (dpHealth)
  );

  // R3: no word is taken while a soft reset is held
  a_r3_ready_low: assert property (@(posedge clk) disable iff (!rstN)
    strobes.flush |-> !srcReady);

endmodule

// File: tb/rng_regfront_bench.sv
module rng_regfront_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int RAND_STEPS = 3000;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        srcValid = 1'b0;
  logic [31:0] srcData = '0;
  logic        srcReady;
  logic        injLockout = 1'b0;
  logic        injHealthFail = 1'b0;

  int nChecks = 0;
  int nErrors = 0;
  bit done = 1'b0;

  // Reference state derived from the requirements
  logic [12:0] mCtrl = '0;
  logic        mRc = 1'b0;
  logic        mRr = 1'b0;
  logic        mLock = 1'b0;
  logic        mHealth = 1'b0;
  logic [31:0] mQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rng_regfront u_rng_regfront (
    .clk          (clk),
    .rstN         (rstN),
    .busSel       (busSel),
    .busWrite     (busWrite),
    .busAddr      (busAddr),
    .busWdata     (busWdata),
    .busRdata     (busRdata),
    .srcValid     (srcValid),
    .srcData      (srcData),
    .srcReady     (srcReady),
    .injLockout   (injLockout),
    .injHealthFail(injHealthFail)
  );

  function automatic logic [31:0] expRead(input logic [7:0] addr);
    logic held;
    held = mRc || mRr;
    case (addr)
      8'h00: return {19'b0, mCtrl};
      8'h04: return {31'b0, mRc};
      8'h08: return {31'b0, mRr};
      8'h18: return {mLock, 25'b0, mHealth, 5'b0};
      8'h20: return (held || mQ.size() == 0) ? 32'h0 : mQ[0];
      8'h24: return held ? 32'h0 : 32'(mQ.size());
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tagOf(input logic [7:0] addr);
    if (mRc || mRr) begin
      if (addr == 8'h20 || addr == 8'h24) return "R3";
    end
    case (addr)
      8'h00: return "R1";
      8'h04, 8'h08: return "R2";
      8'h18: return "R9";
      8'h20: return (mQ.size() == 0) ? "R6" : "R5";
      8'h24: return "R7";
      default: return "R11";
    endcase
  endfunction

  function automatic logic expReady();
    return mCtrl[0] && !mRc && !mRr && mQ.size() < DEPTH;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One bus/source cycle: drive at negedge, sample mid-cycle, model at posedge
  task automatic step(input logic sel, input logic wr, input logic [7:0] addr,
                      input logic [31:0] wd, input logic sv, input logic [31:0] sd,
                      input logic il, input logic ih, input string tag);
    logic acc;
    logic held;
    @(negedge clk);
    busSel = sel; busWrite = wr; busAddr = addr; busWdata = wd;
    srcValid = sv; srcData = sd; injLockout = il; injHealthFail = ih;
    #1;
    chk((mRc || mRr) ? "R3" : "R4", {31'b0, srcReady}, {31'b0, expReady()});
    if (sel && !wr) begin
      chk(tag == "" ? tagOf(addr) : tag, busRdata, expRead(addr));
    end
    acc  = sv && expReady();
    held = mRc || mRr;
    @(posedge clk);
    if (held) begin
      mQ.delete();
    end else begin
      if (sel && !wr && addr == 8'h20 && mQ.size() > 0) void'(mQ.pop_front());
      if (acc) mQ.push_back(sd);
    end
    if (sel && wr) begin
      case (addr)
        8'h00: mCtrl = wd[12:0];
        8'h04: mRc = wd[0];
        8'h08: mRr = wd[0];
        8'h18: begin
          if (wd[31]) mLock = 1'b0;
          if (wd[5])  mHealth = 1'b0;
        end
        default: ;
      endcase
    end
    if (il) mLock = 1'b1;
    if (ih) mHealth = 1'b1;
  endtask

  task automatic rd(input logic [7:0] addr, input string tag);
    step(1'b1, 1'b0, addr, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, tag);
  endtask

  task automatic wr(input logic [7:0] addr, input logic [31:0] d);
    step(1'b1, 1'b1, addr, d, 1'b0, 32'h0, 1'b0, 1'b0, "");
  endtask

  task automatic pushWord(input logic [31:0] d);
    step(1'b0, 1'b0, 8'h0, 32'h0, 1'b1, d, 1'b0, 1'b0, "");
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      nErrors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin : stimulus
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // Reset state (R1, R2, R7, R8)
    rd(8'h00, "R1");
    rd(8'h04, "R2");
    rd(8'h08, "R2");
    rd(8'h18, "R8");
    rd(8'h24, "R7");
    rd(8'h20, "R6");

    // Control field width and upper bits (R1)
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, "R1");
    wr(8'h00, 32'h0000_0AA0);
    rd(8'h00, "R1");
    // Enable off: source refused (R4)
    pushWord(32'h1111_1111);
    rd(8'h24, "R4");
    wr(8'h00, 32'h0000_0001);

    // Fill past depth (R4)
    for (int i = 0; i < DEPTH + 2; i++) pushWord(32'hA000_0000 + i);
    rd(8'h24, "R4");
    // Writes to read-only and unmapped offsets (R11)
    wr(8'h24, 32'h0);
    wr(8'h20, 32'h0);
    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h24, "R11");
    rd(8'h30, "R11");
    rd(8'h0C, "R11");
    // Drain in order (R5), then empty reads (R6)
    for (int i = 0; i < DEPTH; i++) rd(8'h20, "R5");
    rd(8'h20, "R6");
    rd(8'h20, "R6");
    rd(8'h24, "R6");

    // Push and pop in one cycle (R10)
    pushWord(32'h5555_0001);
    pushWord(32'h5555_0002);
    step(1'b1, 1'b0, 8'h20, 32'h0, 1'b1, 32'h5555_0003, 1'b0, 1'b0, "R10");
    rd(8'h24, "R10");
    // Full plus pop: pop happens, push refused (R4)
    for (int i = 0; i < DEPTH; i++) pushWord(32'hB000_0000 + i);
    step(1'b1, 1'b0, 8'h20, 32'h0, 1'b1, 32'hDEAD_BEEF, 1'b0, 1'b0, "R4");
    rd(8'h24, "R4");

    // Soft resets flush and block (R3, R2)
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, "R2");
    rd(8'h24, "R3");
    rd(8'h20, "R3");
    pushWord(32'hC0C0_C0C0);
    wr(8'h08, 32'h0);
    rd(8'h24, "R3");
    pushWord(32'h0101_0101);
    pushWord(32'h0202_0202);
    wr(8'h04, 32'h1);
    rd(8'h04, "R2");
    rd(8'h24, "R3");
    wr(8'h04, 32'h0);
    rd(8'h24, "R3");
    rd(8'h20, "R3");

    // Flags: set, sticky, selective and full clear (R8, R9)
    step(1'b0, 1'b0, 8'h0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b0, "");
    rd(8'h18, "R8");
    step(1'b0, 1'b0, 8'h0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b1, "");
    rd(8'h18, "R8");
    wr(8'h18, 32'h0000_0020);
    rd(8'h18, "R9");
    wr(8'h18, 32'h7FFF_FFDF);
    rd(8'h18, "R9");
    step(1'b0, 1'b0, 8'h0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b1, "");
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h18, "R9");
    // Clear and injection together: flag stays (R9)
    step(1'b1, 1'b1, 8'h18, 32'hFFFF_FFFF, 1'b0, 32'h0, 1'b1, 1'b1, "");
    rd(8'h18, "R9");
    wr(8'h18, 32'hFFFF_FFFF);

    // Constrained random mix
    for (int n = 0; n < RAND_STEPS; n++) begin
      int op;
      logic [7:0] a;
      logic [31:0] d;
      logic sv;
      logic il;
      logic ih;
      op = $urandom_range(0, 99);
      sv = ($urandom_range(0, 9) < 6);
      il = ($urandom_range(0, 29) == 0);
      ih = ($urandom_range(0, 29) == 0);
      d  = $urandom;
      if (op < 50) begin
        case ($urandom_range(0, 8))
          0: a = 8'h00;
          1: a = 8'h04;
          2: a = 8'h08;
          3: a = 8'h18;
          4, 5, 6: a = 8'h20;
          7: a = 8'h24;
          default: a = 8'h10;
        endcase
        step(1'b1, 1'b0, a, 32'h0, sv, $urandom, il, ih, "");
      end else if (op < 70) begin
        case ($urandom_range(0, 5))
          0: begin a = 8'h00; d[0] = ($urandom_range(0, 9) != 0); end
          1: begin a = 8'h04; d[0] = ($urandom_range(0, 3) == 0); end
          2: begin a = 8'h08; d[0] = ($urandom_range(0, 3) == 0); end
          3: a = 8'h18;
          4: a = 8'h24;
          default: a = 8'h20;
        endcase
        step(1'b1, 1'b1, a, d, sv, $urandom, il, ih, "");
        if ((a == 8'h04 || a == 8'h08) && d[0]) begin
          rd(8'h24, "R3");
          wr(a, 32'h0);
        end
      end else begin
        step(1'b0, 1'b0, 8'h0, 32'h0, sv, $urandom, il, ih, "");
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule